// File: doc/BRIEF.md
# Display Coprocessor Power-Up Sequencer

This block brings an attached display coprocessor from power-on to a working state. It works through a fixed, ordered script. First it cycles the coprocessor's active-low power-down pin. It then sends four host commands (wake, external oscillator, 48 MHz PLL, core reset), each followed by its own settle time in milliseconds. Next it polls the coprocessor's identification register until the expected value comes back. Finally it writes the display timing, backlight PWM, GPIO, first display-list words, list swap, pixel-clock divider and touch threshold registers. The pixel-clock divider is written after every other display setting because writing it turns on the visible output.

All bus traffic goes through a separate SPI access engine over a request/acknowledge handshake. A request is presented on `req_valid` with its kind, address, data and byte count, and it completes on the rising edge where `req_ack` is high. For a read, the returned byte is on `rsp_data` in that same cycle. Delays are counted in pulses of `ms_tick`, which arrive once per millisecond. When the last write completes, the block raises `ready`. If the identification poll gives up, the block raises `fail` instead.

The state machine has seven states:
- ST_IDLE: the reset state. It loads the delay timer.
- ST_PD_LOW: holds the pin low and waits.
- ST_PD_HIGH: releases the pin and waits.
- ST_ISSUE: presents the current script step.
- ST_SETTLE: waits out the settle time of a host command.
- ST_DONE: terminal state after a successful sequence.
- ST_FAIL: terminal state after the poll gives up.

Its transitions are:
- IDLE to PD_LOW: unconditional.
- PD_LOW to PD_HIGH, and PD_HIGH to ISSUE: when the timer expires.
- ISSUE to SETTLE: on the handshake of a host command with a non-zero delay.
- SETTLE to ISSUE: when the timer expires.
- ISSUE to ISSUE: on any other handshake, and on an identification mismatch.
- ISSUE to DONE: on the handshake of the last step.
- ISSUE to FAIL: on the final allowed identification mismatch.

Top module: `disp_bringup_seq`

## Requirements
- R1: While `rst_n` is low, `pwr_dn_n`=1, `req_valid`=0, `ready`=0 and `fail`=0.
- R2: After reset, `pwr_dn_n` goes low for exactly 20 counted ticks, then high for exactly 20 counted ticks before the first request, and never goes low again. A tick is counted when `ms_tick` is high in a cycle where a delay is running and `req_valid` is low.
- R3: The first four requests are host commands with kind=0, bytes=1, addr=0 and data[7:0] set to the opcode: 0x00 (wake), 0x44 (external oscillator), 0x62 (48 MHz PLL) and 0x68 (core reset), in that order.
- R4: The counted ticks between a host command's handshake and the next request are 20, 10, 10 and 0 for the four commands in order.
- R5: After core reset, the block issues reads (kind=1, bytes=1, addr 0x102400) back to back with no wait. It repeats the read until the byte returned at the handshake is 0x7C, and it issues nothing else in the meantime.
- R6: Next come 16-bit writes (kind=2, bytes=2) in this order: horizontal cycle, offset, size, sync0, sync1, then vertical cycle, offset, size, sync0, sync1. They go to addresses 0x102400 + 4*slot for slots 1 through 10.
- R7: The block writes PWM frequency 1000 to slot 11, then PWM duty to slot 12. The duty is 100, or 0 when `bl_invert`=1. Both writes are 16-bit.
- R8: The block then writes, in order: GPIO direction 0x82 to slot 13 (1 byte); GPIO value 0x80 to slot 14 (1 byte); display-list word 0x26000007 to 0x100000 (4 bytes); display-list word 0 to 0x100004 (4 bytes); and 1 to the list-swap register at slot 15 (4 bytes).
- R9: The pixel-clock divider (slot 16, 16-bit) is written after all of the above. It is followed only by the touch threshold 1200 (slot 17, 16-bit).
- R10: `ready` rises in the cycle after the touch-threshold handshake and stays high. No request is issued from then on.
- R11: Once `req_valid` is high, it stays high with kind, address, data and byte count unchanged until a handshake.
- R12: After POLL_LIMIT identification reads that all return a mismatch, `fail` rises in the next cycle and stays high. No further request is issued and `ready` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| bl_invert | input | 1 | Backlight polarity strap; 1 selects duty 0 |
| pwr_dn_n | output | 1 | Coprocessor power-down pin, active low |
| req_valid | output | 1 | Request to the SPI access engine |
| req_kind | output | 2 | 0 host command, 1 read, 2 write |
| req_addr | output | 22 | Target address |
| req_data | output | 32 | Write data, or the opcode in bits 7:0 |
| req_bytes | output | 3 | Transfer size in bytes (1, 2 or 4) |
| req_ack | input | 1 | Engine completes the request at this edge |
| rsp_data | input | 8 | Read byte, valid with `req_ack` |
| ready | output | 1 | Sequence finished |
| fail | output | 1 | Identification poll timed out |

## Verification
The bench goes after five corner cases:
- Ticks that land in the handshake cycle itself or while a request is waiting for acknowledge. A design that counts those would shorten its settle delays.
- A core reset with a zero delay. A design that always enters a settle state would stall there or insert a spurious millisecond.
- An identification register that mismatches several times before matching. A design that advances on any read would start configuring a coprocessor that is not yet up.
- A coprocessor that never matches. A design without the limit hangs, and one with an off-by-one count gives up one read early or late.
- The backlight strap and the final order. A duty value that ignores the strap, or a pixel-clock write that is not second to last, would show up as a field or order mismatch in the expected-request queue.

// File: rtl/bringup_pkg.sv
package bringup_pkg;

    typedef enum logic [1:0] {
        OPK_HOST  = 2'd0,
        OPK_READ  = 2'd1,
        OPK_WRITE = 2'd2
    } op_kind_e;

    localparam int ADDR_W    = 22;
    localparam int NUM_HOST  = 4;
    localparam int NUM_TIME  = 10;
    localparam int NUM_STEPS = NUM_HOST + 1 + NUM_TIME + 9;
    localparam int IDX_W     = $clog2(NUM_STEPS);

    localparam logic [ADDR_W-1:0] REG_BASE = 22'h10_2400;
    localparam logic [ADDR_W-1:0] DL_BASE  = 22'h10_0000;

    // register slots, each four bytes above REG_BASE
    localparam int SLOT_ID    = 0;
    localparam int SLOT_PWMF  = 11;
    localparam int SLOT_PWMD  = 12;
    localparam int SLOT_GDIR  = 13;
    localparam int SLOT_GVAL  = 14;
    localparam int SLOT_SWAP  = 15;
    localparam int SLOT_PCLK  = 16;
    localparam int SLOT_TOUCH = 17;

    typedef struct packed {
        op_kind_e          kind;
        logic [ADDR_W-1:0] addr;
        logic [31:0]       data;
        logic [2:0]        bytes;
        logic [7:0]        dly_ms;
        logic              last;
    } step_t;

    function automatic logic [ADDR_W-1:0] slot_addr(input int slot);
        return REG_BASE + ADDR_W'(slot * 4);
    endfunction

endpackage

// File: rtl/bringup_ms_timer.sv
module bringup_ms_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             zero
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (tick && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

    // R4
    cnt_no_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> cnt <= $past(cnt));

endmodule

// File: rtl/bringup_script.sv
module bringup_script
    import bringup_pkg::*;
#(
    parameter logic [7:0]  WAKE_MS    = 8'd20,
    parameter logic [7:0]  CLK_MS     = 8'd10,
    parameter logic [7:0]  OP_ACTIVE  = 8'h00,
    parameter logic [7:0]  OP_EXTOSC  = 8'h44,
    parameter logic [7:0]  OP_PLL48   = 8'h62,
    parameter logic [7:0]  OP_CORERST = 8'h68,
    parameter logic [15:0] H_CYCLE    = 16'd548,
    parameter logic [15:0] H_OFFSET   = 16'd43,
    parameter logic [15:0] H_SIZE     = 16'd480,
    parameter logic [15:0] H_SYNC0    = 16'd0,
    parameter logic [15:0] H_SYNC1    = 16'd41,
    parameter logic [15:0] V_CYCLE    = 16'd292,
    parameter logic [15:0] V_OFFSET   = 16'd12,
    parameter logic [15:0] V_SIZE     = 16'd272,
    parameter logic [15:0] V_SYNC0    = 16'd0,
    parameter logic [15:0] V_SYNC1    = 16'd10,
    parameter logic [15:0] PWM_HZ     = 16'd1000,
    parameter logic [15:0] PWM_DUTY   = 16'd100,
    parameter logic [7:0]  GPIO_DIR   = 8'h82,
    parameter logic [7:0]  GPIO_VAL   = 8'h80,
    parameter logic [31:0] DL_CLEAR   = 32'h2600_0007,
    parameter logic [31:0] DL_END     = 32'h0000_0000,
    parameter logic [15:0] PCLK_DIV   = 16'd5,
    parameter logic [15:0] TOUCH_RZ   = 16'd1200
) (
    input  logic [IDX_W-1:0] idx,
    input  logic             bl_invert,
    output step_t            step
);

    localparam logic [7:0]  HOST_OP  [NUM_HOST] = '{OP_ACTIVE, OP_EXTOSC, OP_PLL48, OP_CORERST};
    localparam logic [7:0]  HOST_DLY [NUM_HOST] = '{WAKE_MS, CLK_MS, CLK_MS, 8'd0};
    localparam logic [15:0] TIMING   [NUM_TIME] = '{H_CYCLE, H_OFFSET, H_SIZE, H_SYNC0, H_SYNC1,
                                                   V_CYCLE, V_OFFSET, V_SIZE, V_SYNC0, V_SYNC1};
    localparam int READ_IDX   = NUM_HOST;
    localparam int TIMING_END = NUM_HOST + NUM_TIME;

    always_comb begin
        step = '{kind: OPK_WRITE, addr: '0, data: '0, bytes: 3'd2, dly_ms: '0, last: 1'b0};
        if (idx < IDX_W'(NUM_HOST)) begin
            step.kind   = OPK_HOST;
            step.bytes  = 3'd1;
            step.data   = {24'h0, HOST_OP[idx[1:0]]};
            step.dly_ms = HOST_DLY[idx[1:0]];
        end else if (idx == IDX_W'(READ_IDX)) begin
            step.kind  = OPK_READ;
            step.bytes = 3'd1;
            step.addr  = slot_addr(SLOT_ID);
        end else if (idx <= IDX_W'(TIMING_END)) begin
            step.addr = slot_addr(int'(idx) - NUM_HOST);
            step.data = {16'h0, TIMING[4'(idx - IDX_W'(READ_IDX + 1))]};
        end else begin
            unique case (idx)
                5'd15: begin
                    step.addr = slot_addr(SLOT_PWMF);
                    step.data = {16'h0, PWM_HZ};
                end
                5'd16: begin
                    step.addr = slot_addr(SLOT_PWMD);
                    step.data = bl_invert ? 32'h0 : {16'h0, PWM_DUTY};
                end
                5'd17: begin
                    step.addr  = slot_addr(SLOT_GDIR);
                    step.bytes = 3'd1;
                    step.data  = {24'h0, GPIO_DIR};
                end
                5'd18: begin
                    step.addr  = slot_addr(SLOT_GVAL);
                    step.bytes = 3'd1;
                    step.data  = {24'h0, GPIO_VAL};
                end
                5'd19: begin
                    step.addr  = DL_BASE;
                    step.bytes = 3'd4;
                    step.data  = DL_CLEAR;
                end
                5'd20: begin
                    step.addr  = DL_BASE + 22'd4;
                    step.bytes = 3'd4;
                    step.data  = DL_END;
                end
                5'd21: begin
                    step.addr  = slot_addr(SLOT_SWAP);
                    step.bytes = 3'd4;
                    step.data  = 32'd1;
                end
                5'd22: begin
                    step.addr = slot_addr(SLOT_PCLK);
                    step.data = {16'h0, PCLK_DIV};
                end
                5'd23: begin
                    step.addr = slot_addr(SLOT_TOUCH);
                    step.data = {16'h0, TOUCH_RZ};
                    step.last = 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/disp_bringup_seq.sv
module disp_bringup_seq
    import bringup_pkg::*;
#(
    parameter logic [7:0]  PWR_MS     = 8'd20,
    parameter logic [7:0]  WAKE_MS    = 8'd20,
    parameter logic [7:0]  CLK_MS     = 8'd10,
    parameter logic [7:0]  ID_VALUE   = 8'h7C,
    parameter int          POLL_LIMIT = 1000,
    parameter logic [15:0] H_CYCLE    = 16'd548,
    parameter logic [15:0] H_OFFSET   = 16'd43,
    parameter logic [15:0] H_SIZE     = 16'd480,
    parameter logic [15:0] H_SYNC0    = 16'd0,
    parameter logic [15:0] H_SYNC1    = 16'd41,
    parameter logic [15:0] V_CYCLE    = 16'd292,
    parameter logic [15:0] V_OFFSET   = 16'd12,
    parameter logic [15:0] V_SIZE     = 16'd272,
    parameter logic [15:0] V_SYNC0    = 16'd0,
    parameter logic [15:0] V_SYNC1    = 16'd10,
    parameter logic [15:0] PCLK_DIV   = 16'd5,
    parameter logic [15:0] TOUCH_RZ   = 16'd1200
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ms_tick,
    input  logic                bl_invert,
    output logic                pwr_dn_n,
    output logic                req_valid,
    output logic [1:0]          req_kind,
    output logic [ADDR_W-1:0]   req_addr,
    output logic [31:0]         req_data,
    output logic [2:0]          req_bytes,
    input  logic                req_ack,
    input  logic [7:0]          rsp_data,
    output logic                ready,
    output logic                fail
);

    localparam int POLL_W = $clog2(POLL_LIMIT + 1);
    localparam int DLY_W  = 8;

    typedef enum logic [2:0] {
        ST_IDLE, ST_PD_LOW, ST_PD_HIGH, ST_ISSUE, ST_SETTLE, ST_DONE, ST_FAIL
    } state_e;

    state_e            state, state_nx;
    logic [IDX_W-1:0]  idx;
    logic [POLL_W-1:0] polls;
    step_t             step;
    logic              tmr_load, tmr_zero;
    logic [DLY_W-1:0]  tmr_val;
    logic              xfer, miss, give_up, advance;

    bringup_script #(
        .WAKE_MS (WAKE_MS),  .CLK_MS  (CLK_MS),
        .H_CYCLE (H_CYCLE),  .H_OFFSET(H_OFFSET), .H_SIZE (H_SIZE),
        .H_SYNC0 (H_SYNC0),  .H_SYNC1 (H_SYNC1),
        .V_CYCLE (V_CYCLE),  .V_OFFSET(V_OFFSET), .V_SIZE (V_SIZE),
        .V_SYNC0 (V_SYNC0),  .V_SYNC1 (V_SYNC1),
        .PCLK_DIV(PCLK_DIV), .TOUCH_RZ(TOUCH_RZ)
    ) u_script (
        .idx      (idx),
        .bl_invert(bl_invert),
        .step     (step)
    );

    bringup_ms_timer #(.CNT_W(DLY_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .tick    (ms_tick),
        .zero    (tmr_zero)
    );

    assign xfer    = (state == ST_ISSUE) && req_ack;
    assign miss    = xfer && (step.kind == OPK_READ) && (rsp_data != ID_VALUE);
    assign give_up = miss && (polls == POLL_W'(POLL_LIMIT - 1));
    assign advance = xfer && !miss;

    // next state and timer control
    always_comb begin
        state_nx = state;
        tmr_load = 1'b0;
        tmr_val  = PWR_MS;
        unique case (state)
            ST_IDLE: begin
                tmr_load = 1'b1;
                state_nx = ST_PD_LOW;
            end
            ST_PD_LOW: begin
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    state_nx = ST_PD_HIGH;
                end
            end
            ST_PD_HIGH: begin
                if (tmr_zero) state_nx = ST_ISSUE;
            end
            ST_ISSUE: begin
                if (give_up) begin
                    state_nx = ST_FAIL;
                end else if (advance) begin
                    if (step.last) begin
                        state_nx = ST_DONE;
                    end else if (step.dly_ms != '0) begin
                        tmr_load = 1'b1;
                        tmr_val  = step.dly_ms;
                        state_nx = ST_SETTLE;
                    end
                end
            end
            ST_SETTLE: begin
                if (tmr_zero) state_nx = ST_ISSUE;
            end
            ST_DONE, ST_FAIL: ;
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // script position and poll count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx   <= '0;
            polls <= '0;
        end else begin
            if (advance && !step.last) idx <= idx + 1'b1;
            if (miss) polls <= polls + 1'b1;
        end
    end

    // outputs
    always_comb begin
        pwr_dn_n  = (state != ST_PD_LOW);
        req_valid = (state == ST_ISSUE);
        req_kind  = step.kind;
        req_addr  = step.addr;
        req_data  = step.data;
        req_bytes = step.bytes;
        ready     = (state == ST_DONE);
        fail      = (state == ST_FAIL);
    end

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ack |=> req_valid && $stable(req_addr) && $stable(req_data)
                                  && $stable(req_kind) && $stable(req_bytes));

    // R2
    pwr_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> pwr_dn_n);

    // R5
    poll_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss && !give_up |=> req_valid && req_kind == 2'd1);

    // R10
    ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready && !req_valid);

    // R12
    fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail |=> fail && !ready && !req_valid);

endmodule

// File: tb/disp_bringup_seq_test.sv
`timescale 1ns/100ps
module disp_bringup_seq_test;

    localparam int POLLS = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ms_tick = 1'b0;
    logic        bl_invert = 1'b0;
    logic        req_ack = 1'b0;
    logic [7:0]  rsp_data = 8'h00;
    logic        pwr_dn_n, req_valid, ready, fail;
    logic [1:0]  req_kind;
    logic [21:0] req_addr;
    logic [31:0] req_data;
    logic [2:0]  req_bytes;

    disp_bringup_seq #(.POLL_LIMIT(POLLS)) uut (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .bl_invert(bl_invert),
        .pwr_dn_n(pwr_dn_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_data(req_data), .req_bytes(req_bytes),
        .req_ack(req_ack), .rsp_data(rsp_data), .ready(ready), .fail(fail)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        logic [1:0]  kind;
        logic [21:0] addr;
        logic [31:0] data;
        logic [2:0]  bytes;
        int          gap;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   tests = 0, fails = 0;
    bit   mon_on = 0, resp_on = 0;
    bit   exp_ready, exp_fail, seen_low, seen_high, first_xfer;
    int   low_ticks, high_ticks, gap_ticks, polls_seen;
    int   wrong_reads, reads_answered, lat;
    bit   prev_wait;
    logic [21:0] prev_addr;
    logic [31:0] prev_data;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    function automatic logic [21:0] reg_at(input int slot);
        return 22'h10_2400 + 22'(slot * 4);
    endfunction

    task automatic add(input logic [1:0] k, input logic [21:0] a, input logic [31:0] d,
                       input logic [2:0] b, input int g, input string t);
        exp_t e;
        e.kind = k; e.addr = a; e.data = d; e.bytes = b; e.gap = g; e.tag = t;
        exp_q.push_back(e);
    endtask

    task automatic build(input logic inv);
        int tv[10];
        tv = '{548, 43, 480, 0, 41, 292, 12, 272, 0, 10};
        exp_q.delete();
        add(2'd0, 22'h0, 32'h00, 3'd1, -1, "R3");
        add(2'd0, 22'h0, 32'h44, 3'd1, 20, "R3");
        add(2'd0, 22'h0, 32'h62, 3'd1, 10, "R3");
        add(2'd0, 22'h0, 32'h68, 3'd1, 10, "R3");
        add(2'd1, reg_at(0), 32'h0, 3'd1, 0, "R5");
        for (int i = 0; i < 10; i++) add(2'd2, reg_at(i + 1), 32'(tv[i]), 3'd2, 0, "R6");
        add(2'd2, reg_at(11), 32'd1000, 3'd2, 0, "R7");
        add(2'd2, reg_at(12), inv ? 32'd0 : 32'd100, 3'd2, 0, "R7");
        add(2'd2, reg_at(13), 32'h82, 3'd1, 0, "R8");
        add(2'd2, reg_at(14), 32'h80, 3'd1, 0, "R8");
        add(2'd2, 22'h10_0000, 32'h2600_0007, 3'd4, 0, "R8");
        add(2'd2, 22'h10_0004, 32'h0, 3'd4, 0, "R8");
        add(2'd2, reg_at(15), 32'd1, 3'd4, 0, "R8");
        add(2'd2, reg_at(16), 32'd5, 3'd2, 0, "R9");
        add(2'd2, reg_at(17), 32'd1200, 3'd2, 0, "R9");
    endtask

    // millisecond ticks, one every ten cycles
    initial begin
        forever begin
            repeat (9) @(posedge clk);
            #1 ms_tick = 1'b1;
            @(posedge clk);
            #1 ms_tick = 1'b0;
        end
    end

    // access engine model: acknowledges after 1 to 3 cycles
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (req_ack) begin
                req_ack = 1'b0;
            end else if (resp_on && req_valid) begin
                if (lat == 0) begin
                    req_ack = 1'b1;
                    if (req_kind == 2'd1) begin
                        rsp_data = (reads_answered < wrong_reads) ? 8'h5A : 8'h7C;
                        reads_answered++;
                    end else begin
                        rsp_data = 8'h00;
                    end
                    lat = (reads_answered + tests) % 3;
                end else begin
                    lat--;
                end
            end
        end
    end

    // reference model, compared every cycle
    always @(negedge clk) begin
        if (rst_n && mon_on) begin
            check(ready == exp_ready, "R10", "ready", ready, exp_ready);
            check(fail == exp_fail, "R12", "fail", fail, exp_fail);
            if (exp_ready || exp_fail)
                check(!req_valid, exp_fail ? "R12" : "R10", "req_valid after end", req_valid, 0);
            if (prev_wait)
                check(req_valid && req_addr == prev_addr && req_data == prev_data,
                      "R11", "request held", req_addr, prev_addr);
            if (seen_low && pwr_dn_n) seen_high = 1;
            check(!(seen_high && !pwr_dn_n), "R2", "pwr_dn_n relapse", pwr_dn_n, 1);
            if (!pwr_dn_n) seen_low = 1;
            if (ms_tick && !req_valid) begin
                if (!pwr_dn_n) low_ticks++;
                else if (seen_low && !first_xfer) high_ticks++;
                else if (first_xfer) gap_ticks++;
            end
            if (req_valid && req_ack) begin
                if (!first_xfer) begin
                    check(low_ticks == 20, "R2", "low ticks", low_ticks, 20);
                    check(high_ticks == 20, "R2", "high ticks", high_ticks, 20);
                    first_xfer = 1;
                end
                if (exp_q.size() == 0) begin
                    check(0, "R10", "unexpected request", req_addr, 0);
                end else begin
                    exp_t e;
                    e = exp_q[0];
                    if (e.gap >= 0)
                        check(gap_ticks == e.gap, (e.tag == "R3" || e.tag == "R5") ? "R4" : e.tag,
                              "settle ticks", gap_ticks, e.gap);
                    check(req_kind == e.kind, e.tag, "kind", req_kind, e.kind);
                    check(req_addr == e.addr, e.tag, "addr", req_addr, e.addr);
                    check(req_data == e.data, e.tag, "data", req_data, e.data);
                    check(req_bytes == e.bytes, e.tag, "bytes", req_bytes, e.bytes);
                    if (e.kind == 2'd1 && rsp_data != 8'h7C) begin
                        polls_seen++;
                        if (polls_seen == POLLS) exp_fail = 1;
                        exp_q[0].gap = 0;
                    end else begin
                        void'(exp_q.pop_front());
                        if (exp_q.size() == 0) exp_ready = 1;
                    end
                end
                gap_ticks = 0;
            end
            prev_wait = req_valid && !req_ack;
            prev_addr = req_addr;
            prev_data = req_data;
        end
    end

    task automatic run_case(input logic inv, input int wrong, input bit expect_fail);
        mon_on = 0; resp_on = 0;
        rst_n = 1'b0;
        bl_invert = inv;
        wrong_reads = wrong; reads_answered = 0; lat = 1;
        exp_ready = 0; exp_fail = 0; seen_low = 0; seen_high = 0; first_xfer = 0;
        low_ticks = 0; high_ticks = 0; gap_ticks = 0; polls_seen = 0; prev_wait = 0;
        build(inv);
        repeat (4) @(negedge clk);
        // R1 reset state
        check(pwr_dn_n == 1'b1, "R1", "pwr_dn_n in reset", pwr_dn_n, 1);
        check(req_valid == 1'b0, "R1", "req_valid in reset", req_valid, 0);
        check(ready == 1'b0 && fail == 1'b0, "R1", "ready/fail in reset", {ready, fail}, 0);
        @(posedge clk);
        #1 rst_n = 1'b1; resp_on = 1; mon_on = 1;
        for (int c = 0; c < 5000 && !(exp_ready || exp_fail); c++) @(negedge clk);
        repeat (40) @(negedge clk);
        if (expect_fail) begin
            check(fail && !ready, "R12", "timed out", fail, 1);
            check(reads_answered == POLLS, "R12", "poll reads", reads_answered, POLLS);
        end else begin
            check(ready && !fail, "R10", "ready at end", ready, 1);
            check(exp_q.size() == 0, "R9", "steps left", exp_q.size(), 0);
            check(reads_answered == wrong + 1, "R5", "poll reads", reads_answered, wrong + 1);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        run_case(1'b0, 3, 1'b0);
        run_case(1'b1, 0, 1'b0);
        run_case(1'b0, 1000, 1'b1);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule